// File: doc/BRIEF.md
# Manchester Line Encoder with Timed End-of-Frame Tail

This block sits between a network controller and a line driver. It takes NRZ transmit data and a transmit enable from the controller and turns each bit into a pair of half-bit line symbols. The line runs at 10 Mb/s from an oscillator clock at twice that rate. The block divides the oscillator clock by two and hands the result back to the controller as its transmit clock. It samples enable and data on the rising edge of that clock, so the controller and the encoder share one timing reference.

The line output is a symbolic two-bit code standing for idle, low and high. When a frame ends there are two behaviours, chosen by a mode pin. In full-step mode the line drops straight to idle. In half-step mode the line is first held high for a set number of oscillator ticks, then kept idle for a further set number of ticks, and a new frame cannot begin until that idle window has run out. A loopback pin copies the coded stream onto a separate tap so that a local decoder can receive the block's own transmission.

Top module: `mchx_encoder`

## Requirements
- R1: While reset is asserted, and at once when it is asserted, `line_o` and `tap_o` are idle (00) and `tx_clk_o` is low. No end-of-frame tail survives a reset.
- R2: `tx_clk_o` toggles on every oscillator edge once reset is released. It is high for one oscillator period and low for the next, which gives a 50% duty cycle.
- R3: `tx_en_i` and `tx_data_i` are sampled on the oscillator edge where `tx_clk_o` rises. A sampled bit is output in the two oscillator periods that follow that edge: the first half-bit while `tx_clk_o` is high, the second half-bit while it is low.
- R4: Line codes are 00 for idle, 01 for low and 10 for high. A data 1 is sent as low then high. A data 0 is sent as high then low.
- R5: When enable is sampled low and no frame or tail is active, the line is idle and `tx_data_i` has no effect.
- R6: With `half_step_i` low, the first sample of a low enable after a frame makes the line idle at once, with no high tail. A new frame may start at the next rising edge of the transmit clock.
- R7: With `half_step_i` high, the first sample of a low enable after a frame drives the line high for HI_TICKS (4) oscillator periods and then idle for IDLE_TICKS (16) periods. The tail's high run may join the high second half of a final data 1.
- R8: While a half-step tail is running, a sampled high enable is ignored and the line stays as the tail dictates. A frame starts at the first transmit-clock rising edge at which the tail has finished.
- R9: With `loop_en_i` high, `tap_o` carries the same code as `line_o` in each cycle. With it low, `tap_o` is idle. `loop_en_i` never changes `line_o`.
- R10: The code 11 never appears on `line_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock, two ticks per bit |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| half_step_i | input | 1 | 1 selects half-step end of frame (high tail then idle), 0 selects full-step |
| loop_en_i | input | 1 | 1 copies the coded stream onto `tap_o` |
| tx_en_i | input | 1 | Transmit enable from the controller |
| tx_data_i | input | 1 | NRZ transmit data from the controller |
| tx_clk_o | output | 1 | Transmit clock to the controller, oscillator divided by two |
| line_o | output | 2 | Line code: 00 idle, 01 low, 10 high |
| tap_o | output | 2 | Loopback copy of the line code, idle when loopback is off |

## Verification
Bit streams of mixed ones and zeros are sent, and each half-bit is compared. This separates a correct encoding from swapped polarity or halves emitted in the wrong order. Frames are ended in both modes and after both a final 0 and a final 1. This shows the immediate idle of full-step mode apart from the timed high tail and its idle window. It also shows how a final 1 merges with the tail. A high enable held through the idle window tests that the tail defers the next frame exactly to its end. A reset in the middle of a tail confirms that no leftover high appears afterwards. Toggling loopback during frames and tails shows that the tap follows the line only when enabled.

// File: rtl/mchx_pkg.sv
package mchx_pkg;
  typedef enum logic [1:0] {
    LN_IDLE = 2'b00,
    LN_LOW  = 2'b01,
    LN_HIGH = 2'b10
  } line_code_e;
endpackage

// File: rtl/mchx_rst_sync.sv
module mchx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/mchx_phase.sv
module mchx_phase (
  input  logic clk,
  input  logic rst_n,
  output logic txclk_o,
  output logic rise_o
);
  logic ph_q, ph_d;

  always_comb ph_d = ~ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

  // the edge that takes ph_q from 0 to 1 is the transmit clock rising edge
  assign txclk_o = ph_q;
  assign rise_o  = ~ph_q;
endmodule

// File: rtl/mchx_tail.sv
module mchx_tail #(
  parameter int HI_TICKS   = 4,
  parameter int IDLE_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic hi_o,
  output logic open_o
);
  localparam int TOTAL = HI_TICKS + IDLE_TICKS;
  localparam int CW    = $clog2(TOTAL + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start_i || (cnt_q != '0);
    if (start_i)            cnt_d = CW'(TOTAL);
    else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
    else                    cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // high while the remaining count is above the idle window
  assign hi_o   = cnt_d > CW'(IDLE_TICKS);
  // a new frame may start on the edge where the count reaches zero
  assign open_o = cnt_q <= CW'(1);
endmodule

// File: rtl/mchx_encoder.sv
module mchx_encoder #(
  parameter int HI_TICKS    = 4,
  parameter int IDLE_TICKS  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       half_step_i,
  input  logic       loop_en_i,
  input  logic       tx_en_i,
  input  logic       tx_data_i,
  output logic       tx_clk_o,
  output logic [1:0] line_o,
  output logic [1:0] tap_o
);
  import mchx_pkg::*;

  logic srst_n;
  logic rise;
  logic tail_go, tail_hi, tail_open;

  logic       act_q, act_d;
  logic       bit_q, bit_d, bit_en;
  line_code_e line_q, tap_q, code_d, tap_d;

  mchx_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  mchx_phase u_phase (
    .clk     (clk),
    .rst_n   (srst_n),
    .txclk_o (tx_clk_o),
    .rise_o  (rise)
  );

  mchx_tail #(.HI_TICKS(HI_TICKS), .IDLE_TICKS(IDLE_TICKS)) u_tail (
    .clk     (clk),
    .rst_n   (srst_n),
    .start_i (tail_go),
    .hi_o    (tail_hi),
    .open_o  (tail_open)
  );

  always_comb begin
    act_d   = act_q;
    bit_d   = bit_q;
    bit_en  = 1'b0;
    tail_go = 1'b0;
    code_d  = LN_IDLE;
    if (rise) begin
      if (tx_en_i && tail_open) begin
        act_d  = 1'b1;
        bit_d  = tx_data_i;
        bit_en = 1'b1;
        code_d = tx_data_i ? LN_LOW : LN_HIGH;
      end else begin
        act_d   = 1'b0;
        tail_go = act_q && half_step_i;
      end
    end else if (act_q) begin
      code_d = bit_q ? LN_HIGH : LN_LOW;
    end
    if (tail_hi) code_d = LN_HIGH;
    tap_d = loop_en_i ? code_d : LN_IDLE;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      act_q  <= 1'b0;
      bit_q  <= 1'b0;
      line_q <= LN_IDLE;
      tap_q  <= LN_IDLE;
    end else begin
      act_q  <= act_d;
      if (bit_en) bit_q <= bit_d;
      line_q <= code_d;
      tap_q  <= tap_d;
    end
  end

  assign line_o = line_q;
  assign tap_o  = tap_q;
endmodule

// File: rtl/mchx_encoder_chk.sv
module mchx_encoder_chk #(
  parameter int HI_TICKS = 4
) (
  input logic       clk,
  input logic       srst_n,
  input logic       tx_en_i,
  input logic       loop_en_i,
  input logic       tx_clk_o,
  input logic [1:0] line_o,
  input logic [1:0] tap_o
);
  localparam int RW     = $clog2(HI_TICKS + 3);
  localparam int RUNMAX = HI_TICKS + 2;

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)                 run_q <= '0;
    else if (line_o != 2'b10)    run_q <= '0;
    else if (run_q != RW'(RUNMAX)) run_q <= run_q + RW'(1);
  end

  // R10
  no_code11_chk: assert property (@(posedge clk) disable iff (!srst_n)
    line_o != 2'b11);

  // R2
  txclk_fall_chk: assert property (@(posedge clk) disable iff (!srst_n)
    tx_clk_o |=> !tx_clk_o);

  // R2
  txclk_rise_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !tx_clk_o |=> tx_clk_o);

  // R4
  low_then_high_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (tx_clk_o && line_o == 2'b01) |=> line_o == 2'b10);

  // R5
  idle_holds_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!tx_clk_o && line_o == 2'b00 && !tx_en_i) |=> line_o == 2'b00);

  // R7
  high_run_bound_chk: assert property (@(posedge clk) disable iff (!srst_n)
    run_q <= RW'(HI_TICKS + 1));

  // R9
  tap_follow_chk: assert property (@(posedge clk) disable iff (!srst_n)
    loop_en_i |=> tap_o == line_o);

  // R9
  tap_quiet_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !loop_en_i |=> tap_o == 2'b00);
endmodule

bind mchx_encoder mchx_encoder_chk #(.HI_TICKS(HI_TICKS)) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .tx_en_i   (tx_en_i),
  .loop_en_i (loop_en_i),
  .tx_clk_o  (tx_clk_o),
  .line_o    (line_o),
  .tap_o     (tap_o)
);

// File: tb/tb_mchx_encoder.sv
module tb_mchx_encoder;
  localparam logic [1:0] CI = 2'b00;
  localparam logic [1:0] CL = 2'b01;
  localparam logic [1:0] CH = 2'b10;
  localparam int NV = 35;

  // {half_step, loop_en, tx_en, tx_data, first half, second half}
  localparam logic [7:0] VEC [NV] = '{
    {1'b0,1'b0,1'b1,1'b1,CL,CH}, // R4 data 1
    {1'b0,1'b0,1'b1,1'b0,CH,CL}, // R4 data 0
    {1'b0,1'b1,1'b1,1'b1,CL,CH}, // R9 tap on
    {1'b0,1'b1,1'b1,1'b1,CL,CH}, // R9
    {1'b0,1'b1,1'b0,1'b0,CI,CI}, // R6 full-step end
    {1'b0,1'b0,1'b0,1'b1,CI,CI}, // R5 data ignored
    {1'b0,1'b0,1'b1,1'b0,CH,CL}, // R3
    {1'b0,1'b0,1'b0,1'b0,CI,CI}, // R6
    {1'b1,1'b0,1'b1,1'b0,CH,CL}, // R3 restart right after full-step end
    {1'b1,1'b1,1'b1,1'b1,CL,CH}, // R9
    {1'b1,1'b1,1'b0,1'b0,CH,CH}, // R7 tail high
    {1'b1,1'b0,1'b0,1'b0,CH,CH}, // R7
    {1'b1,1'b0,1'b1,1'b1,CI,CI}, // R8 enable ignored in idle window
    {1'b1,1'b0,1'b1,1'b0,CI,CI}, // R8
    {1'b1,1'b0,1'b1,1'b0,CI,CI}, // R8
    {1'b1,1'b0,1'b1,1'b0,CI,CI}, // R8
    {1'b1,1'b0,1'b1,1'b0,CI,CI}, // R8
    {1'b1,1'b0,1'b1,1'b0,CI,CI}, // R8
    {1'b1,1'b0,1'b1,1'b0,CI,CI}, // R8
    {1'b1,1'b0,1'b1,1'b0,CI,CI}, // R8
    {1'b1,1'b0,1'b1,1'b0,CH,CL}, // R8 frame starts as the window closes
    {1'b1,1'b0,1'b1,1'b1,CL,CH}, // R4
    {1'b1,1'b1,1'b0,1'b0,CH,CH}, // R7 tail joins final 1
    {1'b1,1'b1,1'b0,1'b0,CH,CH}, // R7
    {1'b1,1'b0,1'b0,1'b0,CI,CI}, // R7 idle window
    {1'b1,1'b0,1'b0,1'b0,CI,CI}, // R7
    {1'b1,1'b0,1'b0,1'b0,CI,CI}, // R7
    {1'b1,1'b0,1'b0,1'b0,CI,CI}, // R7
    {1'b1,1'b0,1'b0,1'b0,CI,CI}, // R7
    {1'b1,1'b0,1'b0,1'b0,CI,CI}, // R7
    {1'b1,1'b0,1'b0,1'b0,CI,CI}, // R7
    {1'b1,1'b0,1'b0,1'b0,CI,CI}, // R7
    {1'b1,1'b0,1'b0,1'b0,CI,CI}, // R5 plain idle after tail
    {1'b1,1'b0,1'b1,1'b1,CL,CH}, // R3
    {1'b0,1'b0,1'b0,1'b0,CI,CI}  // R6
  };
  localparam int VREQ [NV] = '{4,4,9,9,6,5,3,6,3,9,7,7,8,8,8,8,8,8,8,8,8,4,7,7,
                               7,7,7,7,7,7,7,7,5,3,6};

  logic       clk = 1'b0;
  logic       rst_n;
  logic       half_step_i, loop_en_i, tx_en_i, tx_data_i;
  logic       tx_clk_o;
  logic [1:0] line_o, tap_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  mchx_encoder dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .half_step_i (half_step_i),
    .loop_en_i   (loop_en_i),
    .tx_en_i     (tx_en_i),
    .tx_data_i   (tx_data_i),
    .tx_clk_o    (tx_clk_o),
    .line_o      (line_o),
    .tap_o       (tap_o)
  );

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic align();
    repeat (6) @(negedge clk);
    while (tx_clk_o !== 1'b0) @(negedge clk);
  endtask

  task automatic bit_period(input logic en, input logic d, input logic [1:0] ea,
                            input logic [1:0] eb, input string req);
    tx_en_i = en; tx_data_i = d;
    @(negedge clk); chk(req, line_o, ea);
    @(negedge clk); chk(req, line_o, eb);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R3 watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; half_step_i = 1'b0; loop_en_i = 1'b1;
    tx_en_i = 1'b1; tx_data_i = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state, with inputs active
    chk("R1 line in reset", line_o, CI);
    chk("R1 tap in reset", tap_o, CI);
    chk("R1 txclk in reset", {1'b0, tx_clk_o}, 2'b00);
    tx_en_i = 1'b0; loop_en_i = 1'b0;
    rst_n = 1'b1;
    align();

    // R2 divide by two, one period high then one low
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R2 txclk", {1'b0, tx_clk_o}, (k % 2 == 0) ? 2'b01 : 2'b00);
    end

    for (int i = 0; i < NV; i++) begin
      logic       hs, lp, en, d;
      logic [1:0] ea, eb;
      string      tag;
      {hs, lp, en, d, ea, eb} = VEC[i];
      tag = $sformatf("R%0d vec%0d", VREQ[i], i);
      half_step_i = hs; loop_en_i = lp; tx_en_i = en; tx_data_i = d;
      @(negedge clk);
      chk(tag, line_o, ea);
      chk({tag, " tap"}, tap_o, lp ? ea : CI);
      chk("R10 no code 11", {1'b0, line_o == 2'b11}, 2'b00);
      @(negedge clk);
      chk(tag, line_o, eb);
      chk({tag, " tap"}, tap_o, lp ? eb : CI);
    end

    // R1 reset in the middle of a half-step tail
    half_step_i = 1'b1; loop_en_i = 1'b0;
    bit_period(1'b1, 1'b1, CL, CH, "R4 pre-reset bit");
    tx_en_i = 1'b0;
    @(negedge clk); chk("R7 tail start", line_o, CH);
    rst_n = 1'b0;
    #2;
    chk("R1 async line", line_o, CI);
    chk("R1 async txclk", {1'b0, tx_clk_o}, 2'b00);
    @(negedge clk); rst_n = 1'b1;
    align();
    for (int k = 0; k < 12; k++) bit_period(1'b0, 1'b1, CI, CI, "R1 no tail after reset");
    // R8 no window left over from the cut tail
    bit_period(1'b1, 1'b0, CH, CL, "R8 start after reset");
    half_step_i = 1'b0;
    bit_period(1'b0, 1'b0, CI, CI, "R6 end");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule